// File: doc/BRIEF.md
# Character-Level Self-Test Pattern Generator and Checker

This block lets a serial link test itself at full character rate. On the transmit side, a 9-bit register normally holds the next character for the 8B/10B encoder. That character is a byte plus a flag that says whether it is a data code or a special code. When the active-low self-test enable is driven low, the same register becomes a maximal-length linear feedback shift register. It then steps once per character strobe.

Each register state is mapped to one character. A character is a data code, one of twelve special codes, or an explicit code violation. The sequence repeats every 511 characters. Over one period it visits every data byte, every special code and sixteen violation symbols.

On the receive side, a checker locks onto the incoming stream. It loads its own copy of the register from the first received data character. From then on it predicts each following character. A mismatch raises a one-cycle error pulse and sends the checker back to hunting. A run of matches raises a lock flag.

Top module: `bist_char_pattern`

## Requirements
- R1: During and after synchronous reset, `out_byte` is 0, `out_special` and `out_viol` are 0, and `chk_err` and `chk_locked` are 0.
- R2: With `bist_en_n` high, a `tx_stb` pulse makes the character fields show `tx_data` and `tx_special_in` from the next cycle on, with `out_viol` low.
- R3: The character fields keep their value in every cycle that has no `tx_stb`.
- R4: The first `tx_stb` with `bist_en_n` low after the enable was high (or after reset) loads the seed state 0x1FF. This produces data byte 0xFF. Each later strobe steps state s to {s[7:0], s[8]^s[4]}, which is the polynomial x^9+x^5+1.
- R5: In self-test, state s maps to a character as follows. If s[8]=1, the character is data byte s[7:0]. If s[8]=0 and s[7:4]=1111, the character is a violation with byte s[7:0]. Otherwise it is special code k = s[3:0] when that value is below 12, and s[3:0]-12 otherwise.
- R6: The self-test sequence repeats every 511 characters. One period contains all 256 data bytes, all 12 special codes and 16 violations. `out_special` and `out_viol` are never high together.
- R7: While hunting, the checker ignores special and violation characters and raises no error. The first data character b received with `rx_stb` loads the prediction state {1,b} stepped once.
- R8: Once the checker is loaded, a received character that differs from the prediction in byte, special flag or violation flag has three effects on the next cycle: `chk_err` goes high for exactly one cycle, `chk_locked` goes low, and the checker returns to hunting.
- R9: `chk_locked` rises in the cycle after the 9th consecutive matching character that follows the loading character. It is still low after the 8th.
- R10: With `bist_en_n` high, the checker is cleared on the next cycle (`chk_err` and `chk_locked` low), and received characters raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_en_n | input | 1 | Self-test enable, active low |
| tx_stb | input | 1 | Transmit character-rate strobe |
| tx_data | input | 8 | Normal-mode byte |
| tx_special_in | input | 1 | Normal-mode special-code flag |
| out_byte | output | 8 | Character byte to the encoder |
| out_special | output | 1 | Character is a special code |
| out_viol | output | 1 | Character is an explicit violation |
| rx_stb | input | 1 | Receive character strobe |
| rx_byte | input | 8 | Received byte |
| rx_special | input | 1 | Received special flag |
| rx_viol | input | 1 | Received violation flag |
| chk_err | output | 1 | One-cycle mismatch pulse |
| chk_locked | output | 1 | Checker has matched a full run |

## Verification
The delicate coincidence is a mismatch arriving on the very character that would complete the lock run: the comparison failure and the lock qualification fall in the same cycle. The bench loops the generator into the checker, lets eight predicted characters match after the load, and corrupts one byte bit of the ninth. The result is judged correct only if the next cycle shows the error pulse with the lock flag still low, and the cycle after that shows the error cleared.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic {
    CHK_HUNT  = 1'b0,
    CHK_TRACK = 1'b1
  } chk_state_e;
endpackage

// File: rtl/bist_char_map.sv
module bist_char_map #(
  parameter int DATA_W      = 8,
  parameter int NUM_SPECIAL = 12
) (
  input  logic [DATA_W:0]   state,
  input  logic              bist_mode,
  output logic [DATA_W-1:0] ch_byte,
  output logic              ch_special,
  output logic              ch_viol
);
  localparam int LOW_W  = DATA_W / 2;
  localparam int HIGH_W = DATA_W - LOW_W;

  logic [LOW_W-1:0]  lo;
  logic [HIGH_W-1:0] hi;
  logic [LOW_W-1:0]  folded;

  assign lo = state[LOW_W-1:0];
  assign hi = state[DATA_W-1:LOW_W];

  // fold the low field onto the special code range
  generate
    if (NUM_SPECIAL >= (1 << LOW_W)) begin : g_nofold
      assign folded = lo;
    end else begin : g_fold
      localparam logic [LOW_W-1:0] NSP = LOW_W'(NUM_SPECIAL);
      assign folded = (lo < NSP) ? lo : lo - NSP;
    end
  endgenerate

  always_comb begin
    ch_byte    = state[DATA_W-1:0];
    ch_special = 1'b0;
    ch_viol    = 1'b0;
    if (!state[DATA_W]) begin
      if (!bist_mode) begin
        ch_special = 1'b1;
      end else if (&hi) begin
        ch_viol = 1'b1;
      end else begin
        ch_byte    = {{HIGH_W{1'b0}}, folded};
        ch_special = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bist_tx_gen.sv
module bist_tx_gen #(
  parameter int              DATA_W      = 8,
  parameter int              NUM_SPECIAL = 12,
  parameter logic [DATA_W:0] TAPS        = 9'h110,
  parameter logic [DATA_W:0] SEED        = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bist_en_n,
  input  logic              tx_stb,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_special_in,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_special,
  output logic              out_viol
);
  localparam int ST_W = DATA_W + 1;

  function automatic logic [ST_W-1:0] lfsr_step(input logic [ST_W-1:0] s);
    return {s[ST_W-2:0], ^(s & TAPS)};
  endfunction

  logic [ST_W-1:0]   hold_q, hold_d;
  logic              active_q, active_d;
  logic [DATA_W-1:0] m_byte;
  logic              m_special, m_viol;

  // holding register doubles as the LFSR while self-test is active
  always_comb begin
    hold_d   = hold_q;
    active_d = active_q & ~bist_en_n;
    if (tx_stb) begin
      if (bist_en_n) begin
        hold_d = {~tx_special_in, tx_data};
      end else if (!active_q) begin
        hold_d   = SEED;
        active_d = 1'b1;
      end else begin
        hold_d = lfsr_step(hold_q);
      end
    end
  end

  bist_char_map #(.DATA_W(DATA_W), .NUM_SPECIAL(NUM_SPECIAL)) u_map (
    .state     (hold_d),
    .bist_mode (active_d),
    .ch_byte   (m_byte),
    .ch_special(m_special),
    .ch_viol   (m_viol)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= {1'b1, {DATA_W{1'b0}}};
      active_q    <= 1'b0;
      out_byte    <= '0;
      out_special <= 1'b0;
      out_viol    <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      active_q <= active_d;
      if (tx_stb) begin
        out_byte    <= m_byte;
        out_special <= m_special;
        out_viol    <= m_viol;
      end
    end
  end
endmodule

// File: rtl/bist_rx_check.sv
module bist_rx_check
  import bist_pkg::*;
#(
  parameter int              DATA_W      = 8,
  parameter int              NUM_SPECIAL = 12,
  parameter logic [DATA_W:0] TAPS        = 9'h110,
  parameter int              LOCK_LEN    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bist_en_n,
  input  logic              rx_stb,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_special,
  input  logic              rx_viol,
  output logic              chk_err,
  output logic              chk_locked
);
  localparam int ST_W  = DATA_W + 1;
  localparam int CNT_W = $clog2(LOCK_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LOCK_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_LEN - 1);

  function automatic logic [ST_W-1:0] lfsr_step(input logic [ST_W-1:0] s);
    return {s[ST_W-2:0], ^(s & TAPS)};
  endfunction

  chk_state_e        st_q;
  logic [ST_W-1:0]   pred_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] p_byte;
  logic              p_special, p_viol;
  logic              match, rx_is_data;

  bist_char_map #(.DATA_W(DATA_W), .NUM_SPECIAL(NUM_SPECIAL)) u_map (
    .state     (pred_q),
    .bist_mode (1'b1),
    .ch_byte   (p_byte),
    .ch_special(p_special),
    .ch_viol   (p_viol)
  );

  assign match      = (rx_byte == p_byte) && (rx_special == p_special) && (rx_viol == p_viol);
  assign rx_is_data = !rx_special && !rx_viol;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= CHK_HUNT;
      pred_q     <= '0;
      cnt_q      <= '0;
      chk_err    <= 1'b0;
      chk_locked <= 1'b0;
    end else begin
      chk_err <= 1'b0;
      if (bist_en_n) begin
        st_q       <= CHK_HUNT;
        cnt_q      <= '0;
        chk_locked <= 1'b0;
      end else if (rx_stb) begin
        case (st_q)
          CHK_HUNT: begin
            if (rx_is_data) begin
              pred_q <= lfsr_step({1'b1, rx_byte});
              cnt_q  <= '0;
              st_q   <= CHK_TRACK;
            end
          end
          default: begin
            if (match) begin
              pred_q <= lfsr_step(pred_q);
              if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
              if (cnt_q >= CNT_LAST) chk_locked <= 1'b1;
            end else begin
              chk_err    <= 1'b1;
              chk_locked <= 1'b0;
              cnt_q      <= '0;
              st_q       <= CHK_HUNT;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bist_char_pattern.sv
module bist_char_pattern #(
  parameter int              DATA_W      = 8,
  parameter int              NUM_SPECIAL = 12,
  parameter logic [DATA_W:0] TAPS        = 9'h110,
  parameter logic [DATA_W:0] SEED        = 9'h1FF,
  parameter int              LOCK_LEN    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bist_en_n,
  input  logic              tx_stb,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_special_in,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_special,
  output logic              out_viol,
  input  logic              rx_stb,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_special,
  input  logic              rx_viol,
  output logic              chk_err,
  output logic              chk_locked
);
  bist_tx_gen #(
    .DATA_W(DATA_W), .NUM_SPECIAL(NUM_SPECIAL), .TAPS(TAPS), .SEED(SEED)
  ) u_gen (
    .clk          (clk),
    .rst          (rst),
    .bist_en_n    (bist_en_n),
    .tx_stb       (tx_stb),
    .tx_data      (tx_data),
    .tx_special_in(tx_special_in),
    .out_byte     (out_byte),
    .out_special  (out_special),
    .out_viol     (out_viol)
  );

  bist_rx_check #(
    .DATA_W(DATA_W), .NUM_SPECIAL(NUM_SPECIAL), .TAPS(TAPS), .LOCK_LEN(LOCK_LEN)
  ) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bist_en_n (bist_en_n),
    .rx_stb    (rx_stb),
    .rx_byte   (rx_byte),
    .rx_special(rx_special),
    .rx_viol   (rx_viol),
    .chk_err   (chk_err),
    .chk_locked(chk_locked)
  );
endmodule

// File: rtl/bist_char_pattern_sva.sv
module bist_char_pattern_sva #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bist_en_n,
  input logic              tx_stb,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_special_in,
  input logic [DATA_W-1:0] out_byte,
  input logic              out_special,
  input logic              out_viol,
  input logic              rx_stb,
  input logic              chk_err,
  input logic              chk_locked
);
  assert_normal_load_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_stb && bist_en_n) |=> (out_byte == $past(tx_data)) &&
                              (out_special == $past(tx_special_in)) && !out_viol);

  assert_hold_fields_R3: assert property (@(posedge clk) disable iff (rst)
    !tx_stb |=> $stable(out_byte) && $stable(out_special) && $stable(out_viol));

  assert_kind_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(out_special && out_viol));

  assert_err_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
    chk_err |-> !chk_locked);

  assert_err_after_stb_R8: assert property (@(posedge clk) disable iff (rst)
    chk_err |-> $past(rx_stb));

  assert_lock_after_stb_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(chk_locked) |-> $past(rx_stb));

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (rst)
    bist_en_n |=> !chk_locked && !chk_err);
endmodule

bind bist_char_pattern bist_char_pattern_sva #(.DATA_W(DATA_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .bist_en_n    (bist_en_n),
  .tx_stb       (tx_stb),
  .tx_data      (tx_data),
  .tx_special_in(tx_special_in),
  .out_byte     (out_byte),
  .out_special  (out_special),
  .out_viol     (out_viol),
  .rx_stb       (rx_stb),
  .chk_err      (chk_err),
  .chk_locked   (chk_locked)
);

// File: tb/sim_bist_char_pattern.sv
module sim_bist_char_pattern;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bist_en_n = 1'b1;
  logic       tx_stb = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_special_in = 1'b0;
  logic [7:0] out_byte;
  logic       out_special, out_viol;
  logic       rx_stb = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_special = 1'b0;
  logic       rx_viol = 1'b0;
  logic       chk_err, chk_locked;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bist_char_pattern u0 (
    .clk(clk), .rst(rst), .bist_en_n(bist_en_n), .tx_stb(tx_stb),
    .tx_data(tx_data), .tx_special_in(tx_special_in),
    .out_byte(out_byte), .out_special(out_special), .out_viol(out_viol),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .rx_special(rx_special), .rx_viol(rx_viol),
    .chk_err(chk_err), .chk_locked(chk_locked)
  );

  // packing used throughout: {byte, special, viol}
  function automatic logic [8:0] m_step(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  function automatic logic [9:0] m_dec(input logic [8:0] s);
    logic [3:0] k;
    if (s[8]) return {s[7:0], 2'b00};
    if (s[7:4] == 4'hF) return {s[7:0], 2'b01};
    k = (s[3:0] < 4'd12) ? s[3:0] : s[3:0] - 4'd12;
    return {4'h0, k, 2'b10};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] fields();
    return {out_byte, out_special, out_viol};
  endfunction

  task automatic tx_char(output logic [9:0] got);
    @(negedge clk); tx_stb = 1'b1;
    @(negedge clk); tx_stb = 1'b0;
    got = fields();
  endtask

  // one character from generator into checker, optionally corrupted
  task automatic loop_char(input bit corrupt, output logic e, output logic l);
    logic [9:0] g;
    tx_char(g);
    {rx_byte, rx_special, rx_viol} = g ^ (corrupt ? 10'h004 : 10'h000);
    rx_stb = 1'b1;
    @(negedge clk); rx_stb = 1'b0;
    e = chk_err; l = chk_locked;
  endtask

  task automatic rearm();
    @(negedge clk); bist_en_n = 1'b1;
    @(negedge clk); bist_en_n = 1'b0;
  endtask

  task automatic t_reset();
    check(fields() == 10'h0, "R1 fields", fields(), 0);
    check(!chk_err && !chk_locked, "R1 checker", {chk_err, chk_locked}, 0);
  endtask

  task automatic t_normal();
    logic [9:0] g, keep;
    logic [8:0] pats [4] = '{9'h0A5, 9'h13C, 9'h100, 9'h0FF};
    bist_en_n = 1'b1;
    foreach (pats[i]) begin
      tx_data = pats[i][7:0]; tx_special_in = pats[i][8];
      tx_char(g);
      check(g == {pats[i][7:0], pats[i][8], 1'b0}, "R2 load", g, {pats[i][7:0], pats[i][8], 1'b0});
    end
    keep = fields();
    tx_data = 8'h77;
    repeat (3) @(negedge clk);
    check(fields() == keep, "R3 hold", fields(), keep);
    {rx_byte, rx_special, rx_viol} = 10'h155;
    rx_stb = 1'b1; @(negedge clk); rx_stb = 1'b0;
    check(!chk_err && !chk_locked, "R10 rx ignored when off", {chk_err, chk_locked}, 0);
  endtask

  task automatic t_sequence();
    logic [8:0]   s = 9'h1FF;
    logic [9:0]   g, first, e;
    logic [255:0] dseen = '0;
    logic [11:0]  kseen = '0;
    int           nviol = 0, nerr = 0;
    bist_en_n = 1'b0;
    for (int i = 0; i < 512; i++) begin
      tx_char(g);
      e = m_dec(s);
      if (i == 0) begin
        first = g;
        check(g == 10'h3FC, "R4 seed char", g, 10'h3FC);
      end else if (i == 511) begin
        check(g == first, "R6 period 511", g, first);
      end else if (g != e) begin
        nerr++;
        if (nerr < 4) check(1'b0, "R5 step", g, e);
      end
      if (i < 511) begin
        if (!g[1] && !g[0]) dseen[g[9:2]] = 1'b1;
        if (g[1] && g[9:2] < 8'd12) kseen[g[5:2]] = 1'b1;
        if (g[0]) nviol++;
      end
      s = m_step(s);
    end
    check(nerr == 0, "R4 R5 sequence mismatches", nerr, 0);
    check(&dseen, "R6 all data", $countones(dseen), 256);
    check(&kseen, "R6 all specials", kseen, 12'hFFF);
    check(nviol == 16, "R6 violations", nviol, 16);
  endtask

  task automatic t_lock();
    logic e, l;
    rearm();
    {rx_byte, rx_special, rx_viol} = 10'h02A;
    rx_stb = 1'b1; @(negedge clk); rx_stb = 1'b0;
    check(!chk_err && !chk_locked, "R7 hunt ignores special", {chk_err, chk_locked}, 0);
    loop_char(1'b0, e, l);
    check(!e && !l, "R7 load", {e, l}, 0);
    for (int i = 1; i <= 8; i++) begin
      loop_char(1'b0, e, l);
      if (i == 8) check(!l && !e, "R9 not locked after 8", {e, l}, 0);
    end
    loop_char(1'b0, e, l);
    check(l && !e, "R9 locked after 9", {e, l}, 2'b01);
    loop_char(1'b0, e, l);
    check(l && !e, "R9 stays locked", {e, l}, 2'b01);
  endtask

  task automatic t_error();
    logic e, l;
    bit   relocked = 1'b0, spurious = 1'b0;
    loop_char(1'b1, e, l);
    check(e && !l, "R8 mismatch", {e, l}, 2'b10);
    @(negedge clk);
    check(!chk_err, "R8 single-cycle pulse", chk_err, 0);
    for (int i = 0; i < 60 && !relocked; i++) begin
      loop_char(1'b0, e, l);
      if (e) spurious = 1'b1;
      if (l) relocked = 1'b1;
    end
    check(relocked && !spurious, "R7 R8 resync", {relocked, spurious}, 2'b10);
  endtask

  task automatic t_coincide();
    logic e, l;
    rearm();
    loop_char(1'b0, e, l);
    for (int i = 0; i < 8; i++) loop_char(1'b0, e, l);
    check(!l, "R9 pre-coincide", l, 0);
    loop_char(1'b1, e, l);
    check(e && !l, "R8 R9 error on lock char", {e, l}, 2'b10);
    @(negedge clk);
    check(!chk_err && !chk_locked, "R8 cleared after pulse", {chk_err, chk_locked}, 0);
  endtask

  task automatic t_disable();
    logic       e, l;
    logic [9:0] g;
    rearm();
    for (int i = 0; i < 10; i++) loop_char(1'b0, e, l);
    check(l, "R9 lock before disable", l, 1);
    @(negedge clk); bist_en_n = 1'b1;
    @(negedge clk);
    check(!chk_locked && !chk_err, "R10 disable clears", {chk_err, chk_locked}, 0);
    tx_data = 8'h5A; tx_special_in = 1'b0;
    tx_char(g);
    check(g == {8'h5A, 2'b00}, "R10 R2 back to normal", g, {8'h5A, 2'b00});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_sequence();
    t_lock();
    t_error();
    t_coincide();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule